// File: doc/BRIEF.md
# Hamming-Coded Parallel Transform Corrector

This block guards four linear transform engines that run side by side (for example four FFTs) with the help of three extra check engines. Each check engine is fed the sum of a fixed subset of the data engines' inputs. Because the transform is linear, each check engine's output must equal the same sum taken over the data engines' outputs. One output sample from each of the seven engines arrives together on one stream beat, as complex values with signed real and imaginary fields.

For every beat the block forms three check differences, one per check engine. Each difference is tested against a programmable tolerance to produce a 3-bit syndrome. The syndrome is decoded as a single-error-correcting Hamming code. When a data engine is blamed, its output is replaced by the check engine's output minus the other data outputs in that check. When a check engine is blamed, or nothing fails, the data passes through unchanged. At most one engine is assumed to be faulty at a time.

The sample stream uses valid/ready on both sides. An accepted beat emerges two cycles later when the output is not stalled. `in_ready` is high whenever the output register is empty or is being taken in the same cycle. While `out_valid` is high and `out_ready` is low, the whole pipeline freezes and the output beat is held unchanged. The tolerance `thr` is a plain control input and must be held steady while beats are in flight.

Top module: `xform_hamming_fix`

## Requirements
- R1: Check engine 1 covers data engines {1,2,3}, check engine 2 covers {1,2,4} and check engine 3 covers {1,3,4}. Syndrome bit 2 belongs to check 1, bit 1 to check 2 and bit 0 to check 3.
- R2: A check fails when the absolute difference between its check output and the sum of its covered data outputs is strictly greater than `thr` in either the real or the imaginary component. A difference equal to `thr` passes.
- R3: The location code `out_loc` follows from the syndrome as 111→1, 110→2, 101→3, 011→4 (data engines 1 to 4), 100→5, 010→6, 001→7 (check engines 1 to 3), and 000→0.
- R4: When `out_loc` names data engine n, that engine's real and imaginary outputs are rebuilt from the lowest-numbered check covering it. The rebuilt value is that check output minus the other two data outputs in the check, taken modulo 2^W.
- R5: When `out_loc` is 0 or names a check engine, all four data outputs appear unchanged, including any error too small to fail a check.
- R6: `in_ready` equals (not `out_valid`) or `out_ready`. A beat accepted into an idle pipeline with `out_ready` high appears on the output two rising edges later.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and all output fields hold their values on the next cycle.
- R8: During reset, and right after it, `out_valid` is low and `in_ready` is high.
- R9: `out_err` is high exactly when the output syndrome is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr | input | W | Unsigned tolerance for each check component |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_d_re | input | 4*W | Real parts of data engines 1..4, engine n in slice n-1 |
| in_d_im | input | 4*W | Imaginary parts of data engines 1..4 |
| in_k_re | input | 3*W | Real parts of check engines 1..3 |
| in_k_im | input | 3*W | Imaginary parts of check engines 1..3 |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream takes the output beat |
| out_q_re | output | 4*W | Corrected real parts of data engines 1..4 |
| out_q_im | output | 4*W | Corrected imaginary parts of data engines 1..4 |
| out_syn | output | 3 | Syndrome of this beat |
| out_loc | output | 3 | Fault location code |
| out_err | output | 1 | Some check failed on this beat |

## Verification
On every cycle, the checker enforces the output stall rule and the ready rule. It also checks that the error flag agrees with the syndrome and that each location code arrives with the syndrome weight it implies (three or two bits for a data engine, one for a check engine). Only the bench scenarios can show the arithmetic side. These cover which subset each check covers and the strict tolerance boundary at thr and thr+1 for each component and sign. They also cover the values of rebuilt outputs and the pass-through of sub-threshold errors. A sweep injects faults into each of the seven engines under three tolerances, with a changing back-pressure pattern.

// File: rtl/xhc_pkg.sv
`timescale 1ns/1ps
package xhc_pkg;
  localparam int N_DATA = 4;
  localparam int N_CHK  = 3;
  localparam int SYN_W  = N_CHK;

  typedef enum logic [2:0] {
    LOC_NONE = 3'd0,
    LOC_D1   = 3'd1,
    LOC_D2   = 3'd2,
    LOC_D3   = 3'd3,
    LOC_D4   = 3'd4,
    LOC_C1   = 3'd5,
    LOC_C2   = 3'd6,
    LOC_C3   = 3'd7
  } loc_t;

  // Coverage of each check engine over data engines (bit i = data engine i+1).
  function automatic logic [N_DATA-1:0] chk_mask(input int c);
    case (c)
      0:       return 4'b0111;
      1:       return 4'b1011;
      default: return 4'b1101;
    endcase
  endfunction

  // Lowest-numbered check that covers data engine e.
  function automatic int first_check(input int e);
    for (int c = 0; c < N_CHK; c++)
      if (chk_mask(c)[e]) return c;
    return 0;
  endfunction
endpackage

// File: rtl/xhc_check.sv
`timescale 1ns/1ps
module xhc_check
  import xhc_pkg::*;
#(
  parameter int W = 12,
  parameter logic [N_DATA-1:0] MASK = 4'b0111
) (
  input  logic [N_DATA*W-1:0] d_re,
  input  logic [N_DATA*W-1:0] d_im,
  input  logic [W-1:0]        k_re,
  input  logic [W-1:0]        k_im,
  input  logic [W-1:0]        thr,
  output logic                fail
);
  localparam int SW = W + 3;

  logic signed [SW-1:0] sum_re, sum_im, dif_re, dif_im;
  logic [SW-1:0]        mag_re, mag_im;

  always_comb begin
    sum_re = '0;
    sum_im = '0;
    for (int i = 0; i < N_DATA; i++) begin
      if (MASK[i]) begin
        sum_re = sum_re + {{3{d_re[i*W+W-1]}}, d_re[i*W +: W]};
        sum_im = sum_im + {{3{d_im[i*W+W-1]}}, d_im[i*W +: W]};
      end
    end
    dif_re = {{3{k_re[W-1]}}, k_re} - sum_re;
    dif_im = {{3{k_im[W-1]}}, k_im} - sum_im;
    mag_re = dif_re[SW-1] ? SW'(-dif_re) : SW'(dif_re);
    mag_im = dif_im[SW-1] ? SW'(-dif_im) : SW'(dif_im);
    fail   = (mag_re > {3'b000, thr}) || (mag_im > {3'b000, thr});
  end
endmodule

// File: rtl/xhc_locate.sv
`timescale 1ns/1ps
module xhc_locate
  import xhc_pkg::*;
(
  input  logic [SYN_W-1:0] syn,
  output loc_t             loc
);
  always_comb begin
    case (syn)
      3'b111:  loc = LOC_D1;
      3'b110:  loc = LOC_D2;
      3'b101:  loc = LOC_D3;
      3'b011:  loc = LOC_D4;
      3'b100:  loc = LOC_C1;
      3'b010:  loc = LOC_C2;
      3'b001:  loc = LOC_C3;
      default: loc = LOC_NONE;
    endcase
  end
endmodule

// File: rtl/xhc_rebuild.sv
`timescale 1ns/1ps
module xhc_rebuild
  import xhc_pkg::*;
#(
  parameter int W = 12
) (
  input  logic [N_DATA*W-1:0] d,
  input  logic [N_CHK*W-1:0]  k,
  input  loc_t                loc,
  output logic [N_DATA*W-1:0] q
);
  for (genvar e = 0; e < N_DATA; e++) begin : g_eng
    localparam int C = first_check(e);
    localparam logic [N_DATA-1:0] M = chk_mask(C);
    logic [W-1:0] rb;

    always_comb begin
      rb = k[C*W +: W];
      for (int i = 0; i < N_DATA; i++)
        if (M[i] && i != e) rb = rb - d[i*W +: W];
    end

    assign q[e*W +: W] = (loc == loc_t'(e + 1)) ? rb : d[e*W +: W];
  end
endmodule

// File: rtl/xform_hamming_fix.sv
`timescale 1ns/1ps
module xform_hamming_fix
  import xhc_pkg::*;
#(
  parameter int W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [W-1:0]        thr,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [N_DATA*W-1:0] in_d_re,
  input  logic [N_DATA*W-1:0] in_d_im,
  input  logic [N_CHK*W-1:0]  in_k_re,
  input  logic [N_CHK*W-1:0]  in_k_im,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [N_DATA*W-1:0] out_q_re,
  output logic [N_DATA*W-1:0] out_q_im,
  output logic [SYN_W-1:0]    out_syn,
  output logic [2:0]          out_loc,
  output logic                out_err
);
  logic                adv;
  logic                s1_v;
  logic [N_DATA*W-1:0] s1_d_re, s1_d_im;
  logic [N_CHK*W-1:0]  s1_k_re, s1_k_im;
  logic [SYN_W-1:0]    syn;
  loc_t                loc;
  logic [N_DATA*W-1:0] fix_re, fix_im;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v      <= 1'b0;
      out_valid <= 1'b0;
    end else if (adv) begin
      s1_v      <= in_valid;
      out_valid <= s1_v;
    end
  end

  always_ff @(posedge clk) begin
    if (adv && in_valid) begin
      s1_d_re <= in_d_re;
      s1_d_im <= in_d_im;
      s1_k_re <= in_k_re;
      s1_k_im <= in_k_im;
    end
  end

  for (genvar c = 0; c < N_CHK; c++) begin : g_chk
    xhc_check #(.W(W), .MASK(chk_mask(c))) u_chk (
      .d_re (s1_d_re),
      .d_im (s1_d_im),
      .k_re (s1_k_re[c*W +: W]),
      .k_im (s1_k_im[c*W +: W]),
      .thr  (thr),
      .fail (syn[SYN_W-1-c])
    );
  end

  xhc_locate u_loc (
    .syn (syn),
    .loc (loc)
  );

  xhc_rebuild #(.W(W)) u_fix_re (
    .d   (s1_d_re),
    .k   (s1_k_re),
    .loc (loc),
    .q   (fix_re)
  );

  xhc_rebuild #(.W(W)) u_fix_im (
    .d   (s1_d_im),
    .k   (s1_k_im),
    .loc (loc),
    .q   (fix_im)
  );

  always_ff @(posedge clk) begin
    if (adv && s1_v) begin
      out_q_re <= fix_re;
      out_q_im <= fix_im;
      out_syn  <= syn;
      out_loc  <= loc;
      out_err  <= |syn;
    end
  end
endmodule

// File: rtl/xhc_sva.sv
`timescale 1ns/1ps
module xhc_sva
  import xhc_pkg::*;
#(
  parameter int W = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic [N_DATA*W-1:0] out_q_re,
  input logic [N_DATA*W-1:0] out_q_im,
  input logic [SYN_W-1:0]    out_syn,
  input logic [2:0]          out_loc,
  input logic                out_err
);
  // R7: a stalled beat is held unchanged
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_q_re) && $stable(out_q_im)
      && $stable(out_syn) && $stable(out_loc));

  // R6: an empty output register always admits a beat
  p_ready_when_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R9: error flag agrees with syndrome
  p_err_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_err == (out_syn != '0)));

  // R3: a data engine location needs at least two failing checks
  p_loc_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_loc >= 3'd1 && out_loc <= 3'd4 |-> $countones(out_syn) >= 2);

  // R3: a check engine location comes from exactly one failing check
  p_loc_chk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_loc >= 3'd5 |-> $countones(out_syn) == 1);

  // R3: no location means a clean syndrome
  p_loc_none_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_loc == 3'd0 |-> out_syn == '0);
endmodule

bind xform_hamming_fix xhc_sva #(.W(W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_q_re  (out_q_re),
  .out_q_im  (out_q_im),
  .out_syn   (out_syn),
  .out_loc   (out_loc),
  .out_err   (out_err)
);

// File: tb/xform_hamming_fix_tb.sv
`timescale 1ns/1ps
module xform_hamming_fix_tb_top;
  localparam int W  = 12;
  localparam int ND = 4;
  localparam int NC = 3;
  localparam int NS = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  thr = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [ND*W-1:0] in_d_re = '0, in_d_im = '0;
  logic [NC*W-1:0] in_k_re = '0, in_k_im = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [ND*W-1:0] out_q_re, out_q_im;
  logic [2:0]    out_syn, out_loc;
  logic          out_err;

  int total = 0;
  int bad   = 0;
  int thr_cur = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xform_hamming_fix #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .thr(thr),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_d_re(in_d_re), .in_d_im(in_d_im), .in_k_re(in_k_re), .in_k_im(in_k_im),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_q_re(out_q_re), .out_q_im(out_q_im),
    .out_syn(out_syn), .out_loc(out_loc), .out_err(out_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---- stimulus model ----
  function automatic int gv(int j, int e, int comp);
    return ((j * 37 + e * 53 + comp * 71) % 301) - 150;
  endfunction
  function automatic int tgt(int j);    return j % 8; endfunction
  function automatic int mag(int j);    return thr_cur + ((j / 8) % 2); endfunction
  function automatic int csel(int j);   return (j / 16) % 2; endfunction
  function automatic int errv(int j);   return (((j / 32) % 2) != 0) ? -mag(j) : mag(j); endfunction
  // R1 coverage: check 0 {1,2,3}, check 1 {1,2,4}, check 2 {1,3,4}
  function automatic bit mem(int c, int e);
    return !((c == 0 && e == 3) || (c == 1 && e == 2) || (c == 2 && e == 1));
  endfunction
  function automatic bit detected(int j);
    return (tgt(j) != 0) && (mag(j) > thr_cur);
  endfunction
  function automatic int exp_syn(int j);
    if (!detected(j)) return 0;
    case (tgt(j))
      1: return 7; 2: return 6; 3: return 5; 4: return 3;
      5: return 4; 6: return 2; default: return 1;
    endcase
  endfunction
  function automatic int exp_q(int j, int e, int comp);
    int v = gv(j, e, comp);
    if (tgt(j) == e + 1 && csel(j) == comp && !detected(j)) v += errv(j);
    return v;
  endfunction

  task automatic drive(int j);
    for (int e = 0; e < ND; e++) begin
      int vr = gv(j, e, 0), vi = gv(j, e, 1);
      if (tgt(j) == e + 1) begin
        if (csel(j) == 0) vr += errv(j); else vi += errv(j);
      end
      in_d_re[e*W +: W] = W'(vr);
      in_d_im[e*W +: W] = W'(vi);
    end
    for (int c = 0; c < NC; c++) begin
      int sr = 0, si = 0;
      for (int e = 0; e < ND; e++) if (mem(c, e)) begin
        sr += gv(j, e, 0);
        si += gv(j, e, 1);
      end
      if (tgt(j) == c + 5) begin
        if (csel(j) == 0) sr += errv(j); else si += errv(j);
      end
      in_k_re[c*W +: W] = W'(sr);
      in_k_im[c*W +: W] = W'(si);
    end
  endtask

  task automatic check_out(int j);
    bit okd = 1;
    int a = 0, x = 0;
    for (int e = 0; e < ND; e++) begin
      int ar = int'($signed(out_q_re[e*W +: W]));
      int ai = int'($signed(out_q_im[e*W +: W]));
      if (ar != exp_q(j, e, 0)) begin okd = 0; a = ar; x = exp_q(j, e, 0); end
      if (ai != exp_q(j, e, 1)) begin okd = 0; a = ai; x = exp_q(j, e, 1); end
    end
    // R4 rebuilt data engines / R5 unchanged data otherwise
    chk(okd, (detected(j) && tgt(j) <= 4) ? "R4 rebuilt data" : "R5 passed data", a, x);
    chk(int'(out_syn) == exp_syn(j), "R1/R2 syndrome", int'(out_syn), exp_syn(j));
    chk(int'(out_loc) == (detected(j) ? tgt(j) : 0), "R3 location",
        int'(out_loc), detected(j) ? tgt(j) : 0);
    chk(out_err == detected(j), "R9 error flag", int'(out_err), int'(detected(j)));
  endtask

  // ---- main sequence ----
  initial begin : main
    int thr_list [3] = '{0, 5, 40};
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R8 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R8 in_ready after reset", int'(in_ready), 1);

    for (int p = 0; p < 3; p++) begin
      int sent = 0, got = 0, cyc = 0;
      bit hold = 0;
      logic [ND*W-1:0] sv_re = '0, sv_im = '0;
      thr_cur = thr_list[p];
      thr = W'(thr_cur);
      while (got < NS) begin
        @(negedge clk);
        cyc++;
        out_ready = ((cyc % 7) != 3) && ((cyc % 11) != 5) && ((cyc % 13) != 2);
        if (sent < NS) begin
          drive(sent);
          in_valid = 1'b1;
        end else begin
          in_valid = 1'b0;
        end
        #1;
        chk(in_ready == (!out_valid || out_ready), "R6 ready rule",
            int'(in_ready), int'(!out_valid || out_ready));
        if (hold) begin
          chk(out_valid && out_q_re == sv_re && out_q_im == sv_im, "R7 stall hold",
              int'(out_valid), 1);
        end
        if (out_valid && out_ready) begin
          check_out(got);
          got++;
        end
        hold  = out_valid && !out_ready;
        sv_re = out_q_re;
        sv_im = out_q_im;
        if (in_valid && in_ready) sent++;
      end
    end

    // R6 latency: idle pipeline, output always ready
    @(negedge clk);
    out_ready = 1'b1;
    drive(9);
    in_valid = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R6 accept when idle", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R6 not after one edge", int'(out_valid), 0);
    @(negedge clk);
    #1;
    chk(out_valid == 1'b1, "R6 valid after two edges", int'(out_valid), 1);
    if (out_valid) check_out(9);
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R6 single beat only", int'(out_valid), 0);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule